// File: doc/BRIEF.md
# Sequential Next-Line Prefetch Engine

This block sits beside a cache and watches every cache reference. From each reference it decides, under one of three selectable trigger policies, whether to ask memory for the lines that follow the referenced line. The requested line addresses go into a small FIFO, and the memory side takes them one at a time through a valid/ready handshake. The cache arrays and the memory system lie outside the block.

The first policy fires on every reference. The second fires only on demand misses. The third keeps one marker bit per cache line. A fill that a prefetch caused clears the marker. A demand fill or any reference sets it. A demand miss fires the trigger, and so does a hit on a line whose marker is still clear, so a stream of prefetched lines keeps the engine running ahead of use. A runtime lookahead input lets one trigger request up to four consecutive lines. No request leaves the page of the triggering line. When the FIFO has no space, the surplus requests are dropped, and the reference stream is never stalled.

Top module: `nlpf_top`

## Requirements
- R1: After reset no request is pending (`pf_valid_o` low) and every marker bit is set.
- R2: With `mode_i` = 0 (every-reference), each reference triggers a request for the following line, whether it hit or missed.
- R3: With `mode_i` = 1 (miss-only), a reference with `ref_hit_i` = 1 triggers nothing, and one with `ref_hit_i` = 0 triggers.
- R4: With `mode_i` = 2 (marker), a reference triggers when it misses, or when it hits a line index whose marker bit is 0.
- R5: A fill with `fill_pf_i` = 1 clears the marker of `fill_idx_i`. A fill with `fill_pf_i` = 0 sets it. Any reference sets the marker of `ref_idx_i`. When a reference and a fill hit the same index in one cycle, the reference wins and the marker ends at 1.
- R6: A trigger at line L with effective depth d requests L+1 through L+d in increasing order. The effective depth is `ahead_i`, except that 0 counts as 1 and values above MAX_AHEAD (4) count as MAX_AHEAD.
- R7: No request is made for a line outside the page of L. A page is 2^PAGE_W lines (64 by default), aligned on the low PAGE_W bits of the line address.
- R8: The FIFO holds DEPTH (8) entries. Requests that do not fit are dropped, the lowest addresses being kept, and the reference inputs have no stall signal.
- R9: Requests appear at `pf_line_o` in the cycle after the clock edge that sampled the reference. They leave in FIFO order, and the head stays stable while `pf_ready_i` is low.
- R10: With `mode_i` = 3 (off), no reference triggers a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Trigger policy: 0 every, 1 miss-only, 2 marker, 3 off |
| ahead_i | input | 3 | Lookahead depth, 1..4 |
| ref_valid_i | input | 1 | A cache reference is present |
| ref_line_i | input | ADDR_W | Line address of the reference |
| ref_hit_i | input | 1 | 1 = hit, 0 = demand miss |
| ref_idx_i | input | IDX_W | Cache line index of the reference |
| fill_valid_i | input | 1 | A line fill completes |
| fill_idx_i | input | IDX_W | Cache line index being filled |
| fill_pf_i | input | 1 | 1 = the fill came from a prefetch |
| pf_valid_o | output | 1 | A prefetch request is offered |
| pf_line_o | output | ADDR_W | Line address requested |
| pf_ready_i | input | 1 | Memory side accepts the request |

## Verification
A reference sampled at a rising edge has its requests in the FIFO right after that edge. The bench drives each stimulus at a falling edge and reads the head at the next falling edge, half a cycle after the capture. A marker update from a fill or a reference takes effect one edge later, and the bench checks it only through the trigger decision of a later reference. Each queued request is checked at a falling edge before `pf_ready_i` is raised for exactly one rising edge. After the expected list has been drained, `pf_valid_o` must be low.

// File: rtl/nlpf_pkg.sv
package nlpf_pkg;
    typedef enum logic [1:0] {
        PF_EVERY  = 2'd0,
        PF_MISS   = 2'd1,
        PF_MARKER = 2'd2,
        PF_OFF    = 2'd3
    } pf_mode_e;
endpackage

// File: rtl/nlpf_trigger.sv
module nlpf_trigger #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             ref_valid_i,
    input  logic             ref_hit_i,
    input  logic [IDX_W-1:0] ref_idx_i,
    input  logic             fill_valid_i,
    input  logic [IDX_W-1:0] fill_idx_i,
    input  logic             fill_pf_i,
    output logic             trig_o
);
    import nlpf_pkg::*;
    localparam int LINES = 1 << IDX_W;

    typedef struct packed {
        logic [LINES-1:0] mark;
    } mark_t;

    mark_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        trig_o = 1'b0;
        if (ref_valid_i) begin
            unique case (pf_mode_e'(mode_i))
                PF_EVERY:  trig_o = 1'b1;
                PF_MISS:   trig_o = !ref_hit_i;
                PF_MARKER: trig_o = !ref_hit_i || !s_q.mark[ref_idx_i];
                default:   trig_o = 1'b0;
            endcase
        end
        if (fill_valid_i)
            s_d.mark[fill_idx_i] = !fill_pf_i;
        if (ref_valid_i)
            s_d.mark[ref_idx_i] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{mark: '1};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/nlpf_gen.sv
module nlpf_gen #(
    parameter int ADDR_W    = 16,
    parameter int PAGE_W    = 6,
    parameter int MAX_AHEAD = 4,
    parameter int AHEAD_W   = 3,
    parameter int NUM_W     = $clog2(MAX_AHEAD + 1)
) (
    input  logic                               trig_i,
    input  logic [ADDR_W-1:0]                  line_i,
    input  logic [AHEAD_W-1:0]                 ahead_i,
    output logic [MAX_AHEAD-1:0][ADDR_W-1:0]   cand_o,
    output logic [NUM_W-1:0]                   num_o
);
    localparam int PAGE_LINES = 1 << PAGE_W;

    int depth;
    logic [MAX_AHEAD-1:0] ok;

    always_comb begin
        if (int'(ahead_i) == 0)              depth = 1;
        else if (int'(ahead_i) > MAX_AHEAD)  depth = MAX_AHEAD;
        else                                 depth = int'(ahead_i);
    end

    for (genvar j = 0; j < MAX_AHEAD; j++) begin : g_cand
        assign cand_o[j] = line_i + ADDR_W'(j + 1);
        assign ok[j] = trig_i && (j < depth) &&
                       (int'(line_i[PAGE_W-1:0]) + j + 1 < PAGE_LINES);
    end

    always_comb begin
        num_o = '0;
        for (int j = 0; j < MAX_AHEAD; j++)
            if (ok[j]) num_o = num_o + NUM_W'(1);
    end
endmodule

// File: rtl/nlpf_fifo.sv
module nlpf_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    parameter int NIN   = 4,
    parameter int NUM_W = $clog2(NIN + 1),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NIN-1:0][W-1:0]    in_i,
    input  logic [NUM_W-1:0]         in_num_i,
    output logic                     out_valid_o,
    output logic [W-1:0]             out_data_o,
    input  logic                     out_ready_i,
    output logic [CNT_W-1:0]         cnt_o
);
    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t s_d, s_q;
    int    free_n;
    int    take;
    logic  pop;

    always_comb begin
        s_d    = s_q;
        pop    = (s_q.cnt != '0) && out_ready_i;
        free_n = DEPTH - int'(s_q.cnt);
        take   = (int'(in_num_i) < free_n) ? int'(in_num_i) : free_n;
        for (int j = 0; j < NIN; j++)
            if (j < take)
                s_d.mem[s_q.wr + PTR_W'(j)] = in_i[j];
        s_d.wr = s_q.wr + PTR_W'(take);
        if (pop) s_d.rd = s_q.rd + PTR_W'(1);
        s_d.cnt = s_q.cnt + CNT_W'(take) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid_o = (s_q.cnt != '0);
    assign out_data_o  = s_q.mem[s_q.rd];
    assign cnt_o       = s_q.cnt;
endmodule

// File: rtl/nlpf_top.sv
module nlpf_top #(
    parameter int ADDR_W    = 16,
    parameter int IDX_W     = 6,
    parameter int PAGE_W    = 6,
    parameter int MAX_AHEAD = 4,
    parameter int AHEAD_W   = 3,
    parameter int DEPTH     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [AHEAD_W-1:0] ahead_i,
    input  logic              ref_valid_i,
    input  logic [ADDR_W-1:0] ref_line_i,
    input  logic              ref_hit_i,
    input  logic [IDX_W-1:0]  ref_idx_i,
    input  logic              fill_valid_i,
    input  logic [IDX_W-1:0]  fill_idx_i,
    input  logic              fill_pf_i,
    output logic              pf_valid_o,
    output logic [ADDR_W-1:0] pf_line_o,
    input  logic              pf_ready_i
);
    localparam int NUM_W = $clog2(MAX_AHEAD + 1);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic                             trig;
    logic [MAX_AHEAD-1:0][ADDR_W-1:0] cand;
    logic [NUM_W-1:0]                 cand_num;
    logic [CNT_W-1:0]                 fifo_cnt;

    nlpf_trigger #(.IDX_W(IDX_W)) trig_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .ref_valid_i(ref_valid_i), .ref_hit_i(ref_hit_i), .ref_idx_i(ref_idx_i),
        .fill_valid_i(fill_valid_i), .fill_idx_i(fill_idx_i), .fill_pf_i(fill_pf_i),
        .trig_o(trig)
    );

    nlpf_gen #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .MAX_AHEAD(MAX_AHEAD),
               .AHEAD_W(AHEAD_W), .NUM_W(NUM_W)) gen_i (
        .trig_i(trig), .line_i(ref_line_i), .ahead_i(ahead_i),
        .cand_o(cand), .num_o(cand_num)
    );

    nlpf_fifo #(.W(ADDR_W), .DEPTH(DEPTH), .NIN(MAX_AHEAD),
                .NUM_W(NUM_W), .CNT_W(CNT_W)) fifo_i (
        .clk(clk), .rst_n(rst_n), .in_i(cand), .in_num_i(cand_num),
        .out_valid_o(pf_valid_o), .out_data_o(pf_line_o),
        .out_ready_i(pf_ready_i), .cnt_o(fifo_cnt)
    );
endmodule

// File: rtl/nlpf_chk.sv
module nlpf_chk #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 6,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_i,
    input logic              ref_valid_i,
    input logic              ref_hit_i,
    input logic [ADDR_W-1:0] ref_line_i,
    input logic              pf_valid_o,
    input logic [ADDR_W-1:0] pf_line_o,
    input logic              pf_ready_i,
    input logic [CNT_W-1:0]  fifo_cnt
);
    logic last_in_page;
    assign last_in_page = &ref_line_i[PAGE_W-1:0];

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_cnt) <= DEPTH); // R8

    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid_o && !pf_ready_i |=> pf_valid_o && $stable(pf_line_o)); // R9

    AST_EVERY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 2'd0 && ref_valid_i && fifo_cnt == '0 && !last_in_page
        |=> pf_valid_o && pf_line_o == $past(ref_line_i) + ADDR_W'(1)); // R2

    AST_MISS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 2'd1 && ref_valid_i && ref_hit_i && fifo_cnt == '0
        |=> !pf_valid_o); // R3

    AST_PAGE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid_i && last_in_page && fifo_cnt == '0 |=> !pf_valid_o); // R7

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 2'd3 && fifo_cnt == '0 |=> !pf_valid_o); // R10
endmodule

bind nlpf_top nlpf_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .ref_valid_i(ref_valid_i),
    .ref_hit_i(ref_hit_i), .ref_line_i(ref_line_i), .pf_valid_o(pf_valid_o),
    .pf_line_o(pf_line_o), .pf_ready_i(pf_ready_i), .fifo_cnt(fifo_cnt)
);

// File: tb/nlpf_top_tb.sv
module nlpf_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [2:0]  ahead = 3'd1;
    logic        ref_valid = 1'b0;
    logic [15:0] ref_line = '0;
    logic        ref_hit = 1'b0;
    logic [5:0]  ref_idx = '0;
    logic        fill_valid = 1'b0;
    logic [5:0]  fill_idx = '0;
    logic        fill_pf = 1'b0;
    logic        pf_valid;
    logic [15:0] pf_line;
    logic        pf_ready = 1'b0;

    int tests = 0;
    int fails = 0;
    logic [15:0] exp_q[$];

    always #10 clk = ~clk;

    nlpf_top dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .ahead_i(ahead),
        .ref_valid_i(ref_valid), .ref_line_i(ref_line), .ref_hit_i(ref_hit),
        .ref_idx_i(ref_idx), .fill_valid_i(fill_valid), .fill_idx_i(fill_idx),
        .fill_pf_i(fill_pf), .pf_valid_o(pf_valid), .pf_line_o(pf_line),
        .pf_ready_i(pf_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic do_ref(input logic [15:0] line, input logic hit, input logic [5:0] idx);
        @(negedge clk);
        ref_valid = 1'b1; ref_line = line; ref_hit = hit; ref_idx = idx;
        @(negedge clk);
        ref_valid = 1'b0;
    endtask

    task automatic do_fill(input logic [5:0] idx, input logic pf);
        @(negedge clk);
        fill_valid = 1'b1; fill_idx = idx; fill_pf = pf;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        foreach (exp_q[i]) begin
            check(pf_valid == 1'b1, req, int'(pf_valid), 1);
            check(pf_line == exp_q[i], req, int'(pf_line), int'(exp_q[i]));
            pf_ready = 1'b1;
            @(negedge clk);
            pf_ready = 1'b0;
        end
        check(pf_valid == 1'b0, req, int'(pf_valid), 0);
        exp_q.delete();
    endtask

    task automatic t_reset;
        check(pf_valid == 1'b0, "R1 reset", int'(pf_valid), 0);
    endtask

    task automatic t_every;
        mode = 2'd0; ahead = 3'd1;
        do_ref(16'h0100, 1'b1, 6'd1);
        exp_q.push_back(16'h0101); drain("R2 every hit");
        do_ref(16'h0200, 1'b0, 6'd2);
        exp_q.push_back(16'h0201); drain("R2 every miss");
    endtask

    task automatic t_miss;
        mode = 2'd1; ahead = 3'd1;
        do_ref(16'h0300, 1'b1, 6'd3);
        drain("R3 hit ignored");
        do_ref(16'h0300, 1'b0, 6'd3);
        exp_q.push_back(16'h0301); drain("R3 miss");
    endtask

    task automatic t_depth;
        mode = 2'd0; ahead = 3'd3;
        do_ref(16'h0410, 1'b1, 6'd4);
        exp_q.push_back(16'h0411); exp_q.push_back(16'h0412); exp_q.push_back(16'h0413);
        drain("R6 depth 3");
        ahead = 3'd7;
        do_ref(16'h0420, 1'b1, 6'd4);
        for (int k = 1; k <= 4; k++) exp_q.push_back(16'h0420 + 16'(k));
        drain("R6 clamp high");
        ahead = 3'd0;
        do_ref(16'h0430, 1'b1, 6'd4);
        exp_q.push_back(16'h0431); drain("R6 clamp zero");
    endtask

    task automatic t_page;
        mode = 2'd0; ahead = 3'd4;
        do_ref(16'h043E, 1'b0, 6'd5);
        exp_q.push_back(16'h043F); drain("R7 page cut");
        do_ref(16'h043F, 1'b0, 6'd5);
        drain("R7 last line");
    endtask

    task automatic t_full;
        mode = 2'd0; ahead = 3'd4;
        do_ref(16'h0600, 1'b1, 6'd6);
        ahead = 3'd3;
        do_ref(16'h0610, 1'b1, 6'd6);
        ahead = 3'd4;
        do_ref(16'h0620, 1'b1, 6'd6);
        do_ref(16'h0630, 1'b1, 6'd6);
        for (int k = 1; k <= 4; k++) exp_q.push_back(16'h0600 + 16'(k));
        for (int k = 1; k <= 3; k++) exp_q.push_back(16'h0610 + 16'(k));
        exp_q.push_back(16'h0621);
        drain("R8 full drop");
    endtask

    task automatic t_hold;
        mode = 2'd0; ahead = 3'd1;
        do_ref(16'h0700, 1'b1, 6'd7);
        for (int k = 0; k < 3; k++) begin
            check(pf_valid && pf_line == 16'h0701, "R9 hold", int'(pf_line), 16'h0701);
            @(negedge clk);
        end
        exp_q.push_back(16'h0701); drain("R9 release");
    endtask

    task automatic t_marker;
        mode = 2'd2; ahead = 3'd1;
        do_ref(16'h0807, 1'b1, 6'd7);
        drain("R4 hit on set marker");
        do_fill(6'd5, 1'b1);
        do_ref(16'h0805, 1'b1, 6'd5);
        exp_q.push_back(16'h0806); drain("R4 first use of prefetched line");
        do_ref(16'h0805, 1'b1, 6'd5);
        drain("R5 reference set marker");
        do_ref(16'h0809, 1'b0, 6'd9);
        exp_q.push_back(16'h080A); drain("R4 miss");
        do_fill(6'd10, 1'b1);
        do_fill(6'd10, 1'b0);
        do_ref(16'h080A, 1'b1, 6'd10);
        drain("R5 demand fill sets");
        @(negedge clk);
        fill_valid = 1'b1; fill_idx = 6'd12; fill_pf = 1'b1;
        ref_valid = 1'b1; ref_line = 16'h080C; ref_hit = 1'b1; ref_idx = 6'd12;
        @(negedge clk);
        fill_valid = 1'b0; ref_valid = 1'b0;
        drain("R5 same cycle no trigger");
        do_ref(16'h080C, 1'b1, 6'd12);
        drain("R5 reference wins");
    endtask

    task automatic t_off;
        mode = 2'd3; ahead = 3'd4;
        do_ref(16'h0900, 1'b0, 6'd1);
        do_ref(16'h0910, 1'b1, 6'd1);
        drain("R10 off");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_every();
        t_miss();
        t_depth();
        t_page();
        t_full();
        t_hold();
        t_marker();
        t_off();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule